// File: doc/BRIEF.md
# Multi-Line Memory Write Sequencer

This block turns one host-memory write command into the beat stream of a cache-line write channel. A command names a line-granular start address (the byte address divided by 64), a burst length of one, two or four lines, a virtual-channel select, a 16-bit request tag, a write request type, and, for partial-line writes, a byte window given as a start byte and a byte count. Once a command is accepted, the block asks an upstream data source for one 512-bit line per beat. It registers each line together with an 80-bit header and presents them on the output.

The first beat of a burst carries the full header with the start-of-packet flag set. The beats that follow clear that flag and carry only the request type and the low two bits of their own line address, which steps up by one on each beat. A downstream almost-full flag stops new beats from being issued without breaking up the burst. A command that breaks the length, alignment, byte-window or request-type rules produces no beats. It raises a single-cycle error pulse instead, and the block stays ready for the next command.

Top module: `line_write_seq`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `beat_valid`, `line_req` and `cmd_err` are 0.
- R2: `cmd_len` 2'h0 gives one beat, 2'h1 gives two beats and 2'h3 gives four beats. 2'h2 is rejected.
- R3: A two-line command with `cmd_addr[0]`=1 is rejected. A four-line command with `cmd_addr[1:0]`≠0 is rejected.
- R4: The first beat's header has byte count in [79:74], channel in [73:72], start-of-packet=1 in [71], byte-mode flag in [70], length code in [69:68], request type in [67:64], start byte in [63:58], line address in [57:16] and tag in [15:0].
- R5: Each later beat has start-of-packet=0, the command's request type in [67:64], and bits [1:0] of (start address + beat index) in [17:16]. Every other header bit is 0.
- R6: A byte-mode command (`cmd_byte_mode`=1) is legal only with `cmd_len`=2'h0 and `cmd_byte_cnt` from 1 to 63. Otherwise it is rejected.
- R7: A line-mode command with a non-zero `cmd_byte_start` or `cmd_byte_cnt` is rejected.
- R8: Only request types 4'h0, 4'h1 and 4'h2 are legal. Any other type is rejected.
- R9: While `tx_afull` is 1, `line_req` stays 0. A burst that is held this way later completes with all its beats, in order.
- R10: A rejected command pulses `cmd_err` for exactly one cycle, in the cycle after acceptance. It produces no beats, and `cmd_ready` stays 1.
- R11: Each cycle with `line_req`=1 is followed in the next cycle by `beat_valid`=1, with `beat_data` equal to the `line_data` sampled in the request cycle.
- R12: `cmd_ready` is 0 from acceptance until the last beat is issued. A command offered in that window is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken when valid |
| cmd_addr | input | 42 | Start line address |
| cmd_len | input | 2 | Burst length code |
| cmd_chan | input | 2 | Virtual-channel select |
| cmd_tag | input | 16 | Request tag |
| cmd_type | input | 4 | Write request type |
| cmd_byte_mode | input | 1 | 1 = partial-line write |
| cmd_byte_start | input | 6 | First byte index of partial write |
| cmd_byte_cnt | input | 6 | Byte count of partial write |
| line_req | output | 1 | Request for one data line this cycle |
| line_data | input | 512 | Line from the data source, valid while requested |
| tx_afull | input | 1 | Downstream almost full |
| beat_valid | output | 1 | Beat present |
| beat_hdr | output | 80 | Beat header |
| beat_data | output | 512 | Beat data |
| cmd_err | output | 1 | Illegal-command pulse |

## Verification
The hardest case to reach from the ports is a four-line burst that is frozen between two beats, with a second command offered while it is frozen. The bench first holds `tx_afull` high across acceptance, so that no beat can leave. It then lowers the flag for exactly one cycle so that a single beat escapes, and offers a competing command while the flag is high again. After releasing the flag, it checks that exactly four beats arrive, with the right per-beat addresses and data, and that the competing command left no trace.

// File: rtl/lws_pkg.sv
// Package for the line write sequencer.
// Holds the command record, the length codes and the fixed header layout.
// Assumes the header layout is fixed at 80 bits with a 42-bit line address.
package lws_pkg;
    localparam int HDR_W   = 80;
    localparam int LADDR_W = 42;
    localparam int TAG_W   = 16;
    localparam int TYPE_W  = 4;
    localparam int BYTE_W  = 6;

    typedef enum logic [1:0] {
        LEN_ONE  = 2'h0,
        LEN_TWO  = 2'h1,
        LEN_BAD  = 2'h2,
        LEN_FOUR = 2'h3
    } len_e;

    typedef struct packed {
        logic [LADDR_W-1:0] addr;
        logic [1:0]         len;
        logic [1:0]         chan;
        logic [TAG_W-1:0]   tag;
        logic [TYPE_W-1:0]  kind;
        logic               byte_mode;
        logic [BYTE_W-1:0]  bstart;
        logic [BYTE_W-1:0]  bcnt;
    } cmd_t;

    // Index of the last beat for a legal length code.
    function automatic logic [1:0] last_idx_of(input logic [1:0] len);
        case (len)
            LEN_ONE: last_idx_of = 2'd0;
            LEN_TWO: last_idx_of = 2'd1;
            default: last_idx_of = 2'd3;
        endcase
    endfunction
endpackage

// File: rtl/lws_cmd_check.sv
// Command legality check.
// Purely combinational. It decides whether a command obeys the length,
// alignment, byte-window and request-type rules.
// Assumes only the low two address bits matter for alignment.
module lws_cmd_check
    import lws_pkg::*;
#(
    parameter int MAX_TYPE = 2
) (
    input  logic [1:0]        addr_lo,
    input  logic [1:0]        len,
    input  logic [TYPE_W-1:0] kind,
    input  logic              byte_mode,
    input  logic [BYTE_W-1:0] bstart,
    input  logic [BYTE_W-1:0] bcnt,
    output logic              legal
);
    logic len_ok, align_ok, type_ok, window_ok;

    // Length code and natural alignment of the start line.
    always_comb begin
        len_ok   = (len != LEN_BAD);
        align_ok = 1'b1;
        if (len == LEN_TWO  && addr_lo[0])        align_ok = 1'b0;
        if (len == LEN_FOUR && addr_lo != 2'b00)  align_ok = 1'b0;
    end

    // Request type must be one of the write types.
    assign type_ok = (int'(kind) <= MAX_TYPE);

    // Byte window rules depend on the mode.
    always_comb begin
        if (byte_mode) window_ok = (len == LEN_ONE) && (bcnt != '0);
        else           window_ok = (bstart == '0) && (bcnt == '0);
    end

    assign legal = len_ok && align_ok && type_ok && window_ok;
endmodule

// File: rtl/lws_beat_ctrl.sv
// Beat controller.
// It tracks whether a burst is active and which beat comes next, and it
// issues one line request per cycle while downstream has room.
// Assumes the command has already been checked as legal when start is high.
module lws_beat_ctrl
    import lws_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] len,
    input  logic       tx_afull,
    output logic       busy,
    output logic       fire,
    output logic [1:0] idx
);
    logic [1:0] last_idx;

    assign fire = busy && !tx_afull;

    // Burst state: load on start, step on each issued beat, end on the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            idx      <= 2'd0;
            last_idx <= 2'd0;
        end else if (start) begin
            busy     <= 1'b1;
            idx      <= 2'd0;
            last_idx <= last_idx_of(len);
        end else if (fire) begin
            if (idx == last_idx) begin
                busy <= 1'b0;
                idx  <= 2'd0;
            end else begin
                idx <= idx + 2'd1;
            end
        end
    end
endmodule

// File: rtl/lws_hdr_build.sv
// Header builder.
// Combinational. It forms the full header for the first beat and the reduced
// header for later beats, whose address bits come from start address + index.
// Assumes natural alignment, so the low-bit sum never needs a carry out.
module lws_hdr_build
    import lws_pkg::*;
(
    input  cmd_t             cmd,
    input  logic [1:0]       idx,
    output logic [HDR_W-1:0] hdr
);
    logic [1:0] addr_lo;

    assign addr_lo = cmd.addr[1:0] + idx;

    // Choose the first-beat layout or the continuation layout.
    always_comb begin
        if (idx == 2'd0) begin
            hdr = {cmd.bcnt, cmd.chan, 1'b1, cmd.byte_mode, cmd.len,
                   cmd.kind, cmd.bstart, cmd.addr, cmd.tag};
        end else begin
            hdr          = '0;
            hdr[67:64]   = cmd.kind;
            hdr[17:16]   = addr_lo;
        end
    end
endmodule

// File: rtl/line_write_seq.sv
// Multi-line memory write sequencer, top level.
// It accepts a write command when idle and rejects illegal commands with a
// one-cycle error pulse. It emits one registered header+data beat for each
// issued line request. Assumes line_data is valid in the cycle line_req is high.
module line_write_seq
    import lws_pkg::*;
#(
    parameter int DATA_W = 512
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [LADDR_W-1:0]  cmd_addr,
    input  logic [1:0]          cmd_len,
    input  logic [1:0]          cmd_chan,
    input  logic [TAG_W-1:0]    cmd_tag,
    input  logic [TYPE_W-1:0]   cmd_type,
    input  logic                cmd_byte_mode,
    input  logic [BYTE_W-1:0]   cmd_byte_start,
    input  logic [BYTE_W-1:0]   cmd_byte_cnt,
    output logic                line_req,
    input  logic [DATA_W-1:0]   line_data,
    input  logic                tx_afull,
    output logic                beat_valid,
    output logic [HDR_W-1:0]    beat_hdr,
    output logic [DATA_W-1:0]   beat_data,
    output logic                cmd_err
);
    cmd_t             cmd_in, cmd_q;
    logic             accept, legal, start, busy, fire;
    logic [1:0]       idx;
    logic [HDR_W-1:0] hdr_next;

    assign cmd_in = '{addr: cmd_addr, len: cmd_len, chan: cmd_chan,
                      tag: cmd_tag, kind: cmd_type, byte_mode: cmd_byte_mode,
                      bstart: cmd_byte_start, bcnt: cmd_byte_cnt};

    assign cmd_ready = !busy;
    assign accept    = cmd_valid && cmd_ready;
    assign start     = accept && legal;
    assign line_req  = fire;

    lws_cmd_check u_check (
        .addr_lo   (cmd_addr[1:0]),
        .len       (cmd_len),
        .kind      (cmd_type),
        .byte_mode (cmd_byte_mode),
        .bstart    (cmd_byte_start),
        .bcnt      (cmd_byte_cnt),
        .legal     (legal)
    );

    lws_beat_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .len      (cmd_len),
        .tx_afull (tx_afull),
        .busy     (busy),
        .fire     (fire),
        .idx      (idx)
    );

    lws_hdr_build u_hdr (
        .cmd (cmd_q),
        .idx (idx),
        .hdr (hdr_next)
    );

    // Hold the accepted command for the length of the burst.
    always_ff @(posedge clk) begin
        if (!rst_n)     cmd_q <= '0;
        else if (start) cmd_q <= cmd_in;
    end

    // Register the outgoing beat and the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_valid <= 1'b0;
            beat_hdr   <= '0;
            beat_data  <= '0;
            cmd_err    <= 1'b0;
        end else begin
            beat_valid <= fire;
            cmd_err    <= accept && !legal;
            if (fire) begin
                beat_hdr  <= hdr_next;
                beat_data <= line_data;
            end
        end
    end
endmodule

// File: rtl/lws_checker.sv
// Assertion checker for line_write_seq, attached by bind.
// Observes ports only and relates them over time.
module lws_checker
    import lws_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_ready,
    input logic             line_req,
    input logic             tx_afull,
    input logic             beat_valid,
    input logic [HDR_W-1:0] beat_hdr,
    input logic             cmd_err
);
    p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_afull |-> !line_req);

    p_req_gives_beat_r11: assert property (@(posedge clk) disable iff (!rst_n)
        line_req |=> beat_valid);

    p_no_req_no_beat_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !line_req |=> !beat_valid);

    p_busy_not_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
        line_req |-> !cmd_ready);

    p_err_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> (!beat_valid && !line_req));

    p_later_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_hdr[71]) |->
        (beat_hdr[79:72] == 8'h00 && beat_hdr[70:68] == 3'b000 &&
         beat_hdr[63:18] == '0 && beat_hdr[15:0] == 16'h0000));

    p_type_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> (beat_hdr[67:64] <= 4'h2));

    p_align_two_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_hdr[71] && beat_hdr[69:68] == 2'h1) |-> !beat_hdr[16]);

    p_align_four_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_hdr[71] && beat_hdr[69:68] == 2'h3) |->
        (beat_hdr[17:16] == 2'b00));
endmodule

bind line_write_seq lws_checker u_lws_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_ready  (cmd_ready),
    .line_req   (line_req),
    .tx_afull   (tx_afull),
    .beat_valid (beat_valid),
    .beat_hdr   (beat_hdr),
    .cmd_err    (cmd_err)
);

// File: tb/sim_line_write_seq.sv
module sim_line_write_seq;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic         cmd_ready;
    logic [41:0]  cmd_addr = '0;
    logic [1:0]   cmd_len = '0;
    logic [1:0]   cmd_chan = '0;
    logic [15:0]  cmd_tag = '0;
    logic [3:0]   cmd_type = '0;
    logic         cmd_byte_mode = 1'b0;
    logic [5:0]   cmd_byte_start = '0;
    logic [5:0]   cmd_byte_cnt = '0;
    logic         line_req;
    logic [511:0] line_data;
    logic         tx_afull = 1'b0;
    logic         beat_valid;
    logic [79:0]  beat_hdr;
    logic [511:0] beat_data;
    logic         cmd_err;

    int n_chk = 0;
    int n_fail = 0;
    int src_cnt = 0;
    int beat_n = 0;
    int err_n = 0;
    int cyc = 0;
    logic [79:0]  cap_hdr [8];
    logic [511:0] cap_data [8];

    always #2 clk = ~clk;

    line_write_seq u0 (.*);

    function automatic logic [511:0] pat(input int n);
        pat = {16{32'hC0DE_0000 ^ n}};
    endfunction

    assign line_data = pat(src_cnt);

    // Data source: next line after each request.
    always @(posedge clk) if (line_req) src_cnt <= src_cnt + 1;

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (beat_valid) begin
                if (beat_n < 8) begin
                    cap_hdr[beat_n]  = beat_hdr;
                    cap_data[beat_n] = beat_data;
                end
                beat_n = beat_n + 1;
            end
            if (cmd_err) err_n = err_n + 1;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: act=%0d exp<=100000 cycles", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [511:0] act, input logic [511:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: act=%0h exp=%0h", rq, what, act, exp);
        end
    endtask

    task automatic drive_cmd(input logic [41:0] a, input logic [1:0] l, input logic [1:0] c,
                             input logic [15:0] t, input logic [3:0] k, input logic bm,
                             input logic [5:0] bs, input logic [5:0] bc);
        cmd_addr = a; cmd_len = l; cmd_chan = c; cmd_tag = t; cmd_type = k;
        cmd_byte_mode = bm; cmd_byte_start = bs; cmd_byte_cnt = bc;
        cmd_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    function automatic logic [79:0] exp_hdr(input int i, input logic [41:0] a, input logic [1:0] l,
                                            input logic [1:0] c, input logic [15:0] t,
                                            input logic [3:0] k, input logic bm,
                                            input logic [5:0] bs, input logic [5:0] bc);
        logic [79:0] h;
        logic [41:0] ai;
        if (i == 0) h = {bc, c, 1'b1, bm, l, k, bs, a, t};
        else begin
            ai = a + 42'(i);
            h = '0; h[67:64] = k; h[17:16] = ai[1:0];
        end
        return h;
    endfunction

    task automatic wait_beats(input int nb);
        for (int w = 0; w < 60 && beat_n < nb; w++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic compare_beats(input string rq, input int base, input int nb,
                                 input logic [41:0] a, input logic [1:0] l, input logic [1:0] c,
                                 input logic [15:0] t, input logic [3:0] k, input logic bm,
                                 input logic [5:0] bs, input logic [5:0] bc);
        chk(beat_n == nb, rq, "beat count", 512'(beat_n), 512'(nb));
        for (int i = 0; i < nb && i < beat_n; i++) begin
            logic [79:0] eh;
            eh = exp_hdr(i, a, l, c, t, k, bm, bs, bc);
            chk(cap_hdr[i] == eh, rq, $sformatf("header beat %0d", i), 512'(cap_hdr[i]), 512'(eh));
            chk(cap_data[i] == pat(base + i), "R11", $sformatf("data beat %0d", i),
                cap_data[i], pat(base + i));
        end
        chk(err_n == 0, rq, "no error on legal command", 512'(err_n), 512'd0);
    endtask

    task automatic run_good(input string rq, input int nb, input logic [41:0] a,
                            input logic [1:0] l, input logic [1:0] c, input logic [15:0] t,
                            input logic [3:0] k, input logic bm, input logic [5:0] bs,
                            input logic [5:0] bc);
        int base;
        beat_n = 0; err_n = 0; base = src_cnt;
        drive_cmd(a, l, c, t, k, bm, bs, bc);
        wait_beats(nb);
        compare_beats(rq, base, nb, a, l, c, t, k, bm, bs, bc);
        chk(cmd_ready == 1'b1, rq, "ready after burst", 512'(cmd_ready), 512'd1);
    endtask

    task automatic run_bad(input string rq, input logic [41:0] a, input logic [1:0] l,
                           input logic [3:0] k, input logic bm, input logic [5:0] bs,
                           input logic [5:0] bc);
        beat_n = 0; err_n = 0;
        drive_cmd(a, l, 2'd1, 16'hBAD0, k, bm, bs, bc);
        chk(cmd_err == 1'b1, rq, "error pulse high (R10)", 512'(cmd_err), 512'd1);
        @(negedge clk);
        chk(cmd_err == 1'b0, "R10", "error pulse one cycle", 512'(cmd_err), 512'd0);
        chk(cmd_ready == 1'b1, "R10", "ready after reject", 512'(cmd_ready), 512'd1);
        repeat (6) @(negedge clk);
        chk(beat_n == 0, rq, "no beats from rejected command", 512'(beat_n), 512'd0);
        chk(err_n == 1, "R10", "exactly one error pulse", 512'(err_n), 512'd1);
    endtask

    task automatic test_reset();
        chk(cmd_ready == 1'b1, "R1", "ready after reset", 512'(cmd_ready), 512'd1);
        chk(beat_valid == 1'b0, "R1", "beat_valid after reset", 512'(beat_valid), 512'd0);
        chk(line_req == 1'b0, "R1", "line_req after reset", 512'(line_req), 512'd0);
        chk(cmd_err == 1'b0, "R1", "cmd_err after reset", 512'(cmd_err), 512'd0);
    endtask

    task automatic test_stall();
        int base, snap;
        logic [41:0] a = 42'h2_0000_0104;
        beat_n = 0; err_n = 0; base = src_cnt;
        tx_afull = 1'b1;
        drive_cmd(a, 2'h3, 2'd3, 16'h7777, 4'h1, 1'b0, 6'd0, 6'd0);
        repeat (8) @(negedge clk);
        chk(beat_n == 0, "R9", "no beat while almost full", 512'(beat_n), 512'd0);
        chk(cmd_ready == 1'b0, "R12", "not ready while burst held", 512'(cmd_ready), 512'd0);
        tx_afull = 1'b0;
        @(negedge clk);
        tx_afull = 1'b1;
        @(negedge clk);
        // Competing command while held: must be ignored.
        snap = src_cnt;
        drive_cmd(42'h0, 2'h0, 2'd0, 16'hDEAD, 4'h0, 1'b0, 6'd0, 6'd0);
        repeat (5) @(negedge clk);
        chk(beat_n == 1, "R9", "one beat escaped during one-cycle release", 512'(beat_n), 512'd1);
        chk(src_cnt == snap, "R9", "no line request while held", 512'(src_cnt), 512'(snap));
        tx_afull = 1'b0;
        wait_beats(4);
        repeat (10) @(negedge clk);
        compare_beats("R9", base, 4, a, 2'h3, 2'd3, 16'h7777, 4'h1, 1'b0, 6'd0, 6'd0);
        chk(beat_n == 4, "R12", "competing command produced nothing", 512'(beat_n), 512'd4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        // Length codes and header layouts.
        run_good("R2", 1, 42'h123_4567_89AB, 2'h0, 2'd2, 16'h1234, 4'h0, 1'b0, 6'd0, 6'd0);
        run_good("R4", 2, 42'h3FF_FFFF_FF02, 2'h1, 2'd1, 16'hA5A5, 4'h1, 1'b0, 6'd0, 6'd0);
        run_good("R5", 4, 42'h000_0000_0010, 2'h3, 2'd0, 16'hFFFF, 4'h2, 1'b0, 6'd0, 6'd0);
        run_good("R6", 1, 42'h000_0000_0007, 2'h0, 2'd3, 16'h0042, 4'h2, 1'b1, 6'd5, 6'd20);
        run_good("R8", 1, 42'h000_0000_0003, 2'h0, 2'd0, 16'h0001, 4'h1, 1'b1, 6'd63, 6'd63);
        // Rejections.
        run_bad("R2", 42'h0, 2'h2, 4'h0, 1'b0, 6'd0, 6'd0);
        run_bad("R3", 42'h1, 2'h1, 4'h0, 1'b0, 6'd0, 6'd0);
        run_bad("R3", 42'h2, 2'h3, 4'h0, 1'b0, 6'd0, 6'd0);
        run_bad("R6", 42'h0, 2'h1, 4'h0, 1'b1, 6'd0, 6'd4);
        run_bad("R6", 42'h0, 2'h0, 4'h0, 1'b1, 6'd8, 6'd0);
        run_bad("R7", 42'h0, 2'h0, 4'h0, 1'b0, 6'd3, 6'd0);
        run_bad("R7", 42'h0, 2'h0, 4'h0, 1'b0, 6'd0, 6'd1);
        run_bad("R8", 42'h0, 2'h0, 4'h4, 1'b0, 6'd0, 6'd0);
        run_bad("R8", 42'h0, 2'h0, 4'hF, 1'b0, 6'd0, 6'd0);
        // Legal burst right after a rejection.
        run_good("R10", 2, 42'h000_0000_0AA4, 2'h1, 2'd2, 16'h0F0F, 4'h0, 1'b0, 6'd0, 6'd0);
        test_stall();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule